// File: doc/BRIEF.md
# Alternating-Counter Oscillator Error Meter

This block sits in the clock domain of a 10 MHz disciplined oscillator and measures that oscillator against a one-pulse-per-second reference. The aim is to give a frequency-locking loop a signed error figure once per measurement window. Two counters alternate. One counts oscillator cycles across a window that lasts a whole number of reference pulses. The other holds the previous window's total for a reader. They trade roles on the same cycle, so every oscillator cycle falls into exactly one window.

The reference input is asynchronous. It passes through a two-flop synchroniser, and its rising edge becomes a one-cycle strobe. The first strobe after reset opens the first window. The window length is sampled from `gate_len` each time a window opens, and a value of zero acts as one.

When a window closes, the block offers two values on a valid/ready port: the raw count, and the count minus the nominal count for that window. The nominal count is the window length times the nominal cycles per pulse, reduced modulo 2^24, and the subtraction is done in 24-bit two's complement. A reader that is too slow misses results; this is recorded in a sticky flag.

Top module: `osc_gate_meter`

## Requirements
- R1: After reset `res_valid` and `overrun` are 0, and no result is offered until one full window has closed. That window starts at the first reference rising edge and ends at the gate-length-th edge after it.
- R2: `res_count` equals the number of oscillator cycles between the reference rising edge that opened the window and the edge that closed it.
- R3: `res_error` equals `res_count` minus (window length × NOM_PER_PPS) modulo 2^24, as a 24-bit two's complement value. It is positive when the oscillator runs fast and negative when it runs slow.
- R4: `gate_len` is sampled only when a window opens, so a change during a window affects only the next window. A value of 0 acts as 1.
- R5: Consecutive results cover adjacent windows with no gap. The cycle that closes one window is the first cycle counted in the next.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_count` and `res_error` hold their values until the next window closes.
- R7: A transfer happens when `res_valid` and `res_ready` are both 1. After a transfer `res_valid` falls on the next cycle, unless a new result arrives on that cycle.
- R8: If a window closes while an earlier result is still untaken, `overrun` becomes 1 and stays 1 until `ovr_clear` is pulsed. If both happen on the same cycle, the new overrun wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous reference pulse |
| gate_len | input | 16 | Window length in reference pulses |
| res_ready | input | 1 | Reader accepts the offered result |
| ovr_clear | input | 1 | Clears the overrun flag |
| res_valid | output | 1 | A finished result is offered |
| res_count | output | 24 | Raw cycle count of the finished window |
| res_error | output | 24 | Signed count minus nominal |
| overrun | output | 1 | Sticky flag: a result was replaced before it was read |

## Verification
The bench drives reference periods that are exactly nominal, longer than nominal and shorter than nominal, with windows of one and two pulses. Together these separate a correct count from an error of the wrong sign or of the wrong scale. One run changes the period from one window to the next and checks that each window gets its own total and that the totals add up with no missing cycle. Other runs hold the reader back or let results pile up, which exercises holding a result, the overrun flag, gate length zero, and a gate length changed mid-window.

// File: rtl/osc_gate_meter.sv
module osc_gate_meter #(
  parameter int CW          = 24,
  parameter int GW          = 16,
  parameter int NOM_PER_PPS = 10_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_in,
  input  logic [GW-1:0] gate_len,
  input  logic          res_ready,
  input  logic          ovr_clear,
  output logic          res_valid,
  output logic [CW-1:0] res_count,
  output logic [CW-1:0] res_error,
  output logic          overrun
);
  localparam logic [CW-1:0] NOM = CW'(NOM_PER_PPS);

  logic [2:0]    sync_q;
  logic          pps_edge, running, sel, res_sel, gate_end;
  logic [CW-1:0] cnt [2];
  logic [GW-1:0] pulses, gate_q, res_gate, gate_eff;
  logic [GW+CW-1:0] nominal_full;

  always_ff @(posedge clk)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pps_in};

  assign pps_edge = sync_q[1] & ~sync_q[2];
  assign gate_eff = (gate_len == '0) ? GW'(1) : gate_len;
  assign gate_end = running && pps_edge && ({1'b0, pulses} + 1'b1 == {1'b0, gate_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      sel      <= 1'b0;
      res_sel  <= 1'b1;
      pulses   <= '0;
      gate_q   <= GW'(1);
      res_gate <= GW'(1);
      cnt[0]   <= '0;
      cnt[1]   <= '0;
    end else if (!running) begin
      if (pps_edge) begin
        running <= 1'b1;
        sel     <= 1'b0;
        cnt[0]  <= CW'(1);
        pulses  <= '0;
        gate_q  <= gate_eff;
      end
    end else if (gate_end) begin
      sel       <= ~sel;
      res_sel   <= sel;
      cnt[~sel] <= CW'(1);
      pulses    <= '0;
      gate_q    <= gate_eff;
      res_gate  <= gate_q;
    end else begin
      cnt[sel] <= cnt[sel] + 1'b1;
      if (pps_edge) pulses <= pulses + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (gate_end)       res_valid <= 1'b1;
      else if (res_ready) res_valid <= 1'b0;
      if (gate_end && res_valid && !res_ready) overrun <= 1'b1;
      else if (ovr_clear)                      overrun <= 1'b0;
    end
  end

  assign nominal_full = res_gate * NOM;
  assign res_count    = cnt[res_sel];
  assign res_error    = res_count - nominal_full[CW-1:0];

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !res_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !gate_end) |=> (res_valid && $stable(res_count) && $stable(res_error)));
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !gate_end) |=> !res_valid);
  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && res_valid && !res_ready) |=> overrun);
  assert_ovr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun);
endmodule

// File: tb/osc_gate_meter_bench.sv
module osc_gate_meter_bench;
  localparam int NOM = 100;
  logic clk = 0, rst_n = 0, pps_in = 0, res_ready = 0, ovr_clear = 0;
  logic [15:0] gate_len = 16'd1;
  logic res_valid, overrun;
  logic [23:0] res_count, res_error;
  int runs = 0, fails = 0;
  int period = 100;
  bit pps_on = 0;

  always #2 clk = ~clk;

  osc_gate_meter #(.NOM_PER_PPS(NOM)) u_osc_gate_meter (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .gate_len(gate_len),
    .res_ready(res_ready), .ovr_clear(ovr_clear), .res_valid(res_valid),
    .res_count(res_count), .res_error(res_error), .overrun(overrun));

  initial forever begin
    @(negedge clk);
    if (pps_on) begin
      pps_in = 1;
      repeat (5) @(negedge clk);
      pps_in = 0;
      repeat (period - 6) @(negedge clk);
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int p, input int g);
    pps_on = 0;
    repeat (300) @(negedge clk);
    rst_n = 0; res_ready = 0; ovr_clear = 0;
    period = p; gate_len = 16'(g);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 5000; i++) begin
      if (res_valid) return;
      @(negedge clk);
    end
    check(0, "watchdog", 0, 1);
  endtask

  task automatic take(output int cnt, output int err);
    wait_valid();
    cnt = int'(res_count);
    err = int'($signed(res_error));
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
  endtask

  task automatic t_reset_and_first();
    int c, e;
    do_reset(100, 1);
    check(!res_valid && !overrun, "R1 reset state", {res_valid, overrun}, 0);
    pps_on = 1;
    repeat (60) @(negedge clk);
    check(!res_valid, "R1 no result before first window", res_valid, 0);
    take(c, e);
    check(c == 100, "R2 locked count", c, 100);
    check(e == 0, "R3 locked error", e, 0);
    @(negedge clk);
    check(!res_valid, "R7 valid drops after transfer", res_valid, 0);
  endtask

  task automatic t_fast_slow();
    int c, e;
    do_reset(103, 1);
    pps_on = 1;
    take(c, e);
    check(c == 103, "R2 fast count", c, 103);
    check(e == 3, "R3 fast error", e, 3);
    do_reset(97, 2);
    pps_on = 1;
    take(c, e);
    check(c == 194, "R2 slow two-pulse count", c, 194);
    check(e == -6, "R3 slow error", e, -6);
  endtask

  task automatic t_gate_rules();
    int c, e;
    do_reset(100, 0);
    pps_on = 1;
    take(c, e);
    check(c == 100 && e == 0, "R4 gate zero acts as one", c, 100);
    do_reset(100, 2);
    pps_on = 1;
    wait (pps_in == 1);
    repeat (30) @(negedge clk);
    gate_len = 16'd5;
    take(c, e);
    check(c == 200, "R4 gate change deferred count", c, 200);
    check(e == 0, "R4 gate change deferred error", e, 0);
  endtask

  task automatic t_adjacent();
    int c1, c2, c3, e;
    do_reset(100, 1);
    pps_on = 1;
    take(c1, e);
    repeat (20) @(negedge clk);
    period = 107;
    take(c2, e);
    take(c3, e);
    check(c2 == 100, "R5 second window", c2, 100);
    check(c3 == 107, "R5 third window", c3, 107);
    check(e == 7, "R5 third window error", e, 7);
    check(c2 + c3 == 207, "R5 windows add up", c2 + c3, 207);
  endtask

  task automatic t_hold_overrun();
    int c, e;
    logic [23:0] snap;
    do_reset(100, 1);
    pps_on = 1;
    wait_valid();
    snap = res_count;
    repeat (60) @(negedge clk);
    check(res_valid && res_count == snap, "R6 held while not ready", res_count, snap);
    check(!overrun, "R8 no overrun yet", overrun, 0);
    repeat (250) @(negedge clk);
    check(overrun, "R8 overrun set", overrun, 1);
    take(c, e);
    check(c == 100, "R8 latest result after overrun", c, 100);
    check(overrun, "R8 overrun held after read", overrun, 1);
    ovr_clear = 1;
    @(negedge clk);
    ovr_clear = 0;
    check(!overrun, "R8 overrun cleared", overrun, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_and_first();
        t_fast_slow();
        t_gate_rules();
        t_adjacent();
        t_hold_overrun();
      end
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule